// File: doc/BRIEF.md
# Addressed serial configuration port for a dual synthesizer

This block takes a three-wire serial stream (a serial clock, a data line and a load strobe) and turns it into the static settings of two frequency synthesizer loops. The three wires are asynchronous to the block. Each is brought into a faster system clock through a two-stage synchronizer, and the serial clock and load edges are found inside that clock domain.

Data enters a 21-bit shift register, most significant bit first, on each rising serial clock edge. When the load strobe rises, the word is copied into one of four holding registers. The two bits shifted in last choose which one. Each holding register has its own field layout:

- the reference divider and control bits of loop 2, plus a test bit;
- the main, swallow and fraction values of loop 2;
- the reference divider and control bits of loop 1;
- the main, swallow and fraction values of loop 1.

The top bit of the shift register is captured on each falling serial clock edge. It is driven out as a chain output whenever both loops' output-select control bits pick the serial-data-out setting. This lets several ports share one data line in a daisy chain. The port keeps working whatever the control bits say about powering the loops down.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset every held field, the test bit and the chain output are 0.
- R2: Each rising serial clock edge with the load strobe low shifts the data bit into bit 0 of the shift register, moving the older bits up, so the first bit sent ends in bit 20 after 21 edges; bits 1..0 are the address.
- R3: Address 00 stores bit 16 as the test bit, bits 15..11 as loop-2 control (bit 15 is control bit 4), and bits 10..2 as the loop-2 reference divider.
- R4: Address 10 stores bits 15..11 as loop-1 control (bit 15 is control bit 4) and bits 10..2 as the loop-1 reference divider.
- R5: Address 11 stores bits 20..12 as the loop-1 main divider, bits 11..7 as the loop-1 swallow count and bits 6..2 as the loop-1 fraction.
- R6: Address 01 stores bits 19..11 as the loop-2 main divider, bits 10..7 as the loop-2 swallow count and bits 6..2 as the loop-2 fraction.
- R7: A load changes only the holding register named by the address; the other three keep their contents, and nothing changes without a load.
- R8: Serial clock rising edges seen while the load strobe is high do not shift; the load happens once, on the rising edge of the strobe.
- R9: When loop-1 control bits 4..3 and loop-2 control bits 4..3 are both 10, the chain output shows the value bit 20 held at the latest falling serial clock edge; otherwise the chain output is 0.
- R10: Reserved bits (20..17 of address 00, 20..16 of address 10, bit 20 of address 01) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_le_i | input | 1 | Load strobe, asynchronous |
| l1_ctrl_o | output | 5 | Loop-1 control bits |
| l1_rdiv_o | output | 9 | Loop-1 reference divider |
| l1_mdiv_o | output | 9 | Loop-1 main divider |
| l1_swal_o | output | 5 | Loop-1 swallow count |
| l1_frac_o | output | 5 | Loop-1 fraction numerator |
| l2_ctrl_o | output | 5 | Loop-2 control bits |
| l2_rdiv_o | output | 9 | Loop-2 reference divider |
| l2_mdiv_o | output | 9 | Loop-2 main divider |
| l2_swal_o | output | 4 | Loop-2 swallow count |
| l2_frac_o | output | 5 | Loop-2 fraction numerator |
| test_o | output | 1 | Test bit |
| chain_o | output | 1 | Daisy-chain serial data out |

## Verification
The bench writes all four addresses with reserved bits set to one and distinct field values. A wrong bit slice, a swapped address decode or a load that leaks into a neighbouring register would show up as a wrong field on one of the other outputs.

It holds the strobe high while pulsing the serial clock with zeros, then strobes again. A design that kept shifting under the strobe would move the address to 00 and overwrite the loop-2 reference settings.

The chain output is compared after every falling edge against a bench-side shift model, both selected and deselected. This exposes capture on the wrong edge, an off-by-one tap, or a missing gate on the output select.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;
  localparam int unsigned WORD_W = 21;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned CTRL_W = 5;
  localparam int unsigned RDIV_W = 9;
  localparam int unsigned MDIV_W = 9;
  localparam int unsigned SW1_W  = 5;
  localparam int unsigned SW2_W  = 4;
  localparam int unsigned FRAC_W = 5;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_L2_REF  = 2'b00,
    ADR_L2_MAIN = 2'b01,
    ADR_L1_REF  = 2'b10,
    ADR_L1_MAIN = 2'b11
  } cfg_addr_e;

  // output-select code that routes the chain data out, per loop
  localparam logic [1:0] SEL_CHAIN = 2'b10;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] stg_q;
    logic [STAGES-1:0] stg_n;

    always_comb begin
      stg_n = {stg_q[STAGES-2:0], async_i[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= stg_n;
    end

    assign sync_o[b] = stg_q[STAGES-1];
  end
endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int unsigned W = 21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en_i,
  input  logic         hold_i,
  input  logic         din_i,
  input  logic         fall_i,
  output logic [W-1:0] word_o,
  output logic         top_q_o
);
  logic [W-1:0] sr_q, sr_n;
  logic         top_q, top_n;

  always_comb begin
    sr_n  = sr_q;
    top_n = top_q;
    if (shift_en_i) sr_n  = {sr_q[W-2:0], din_i};
    if (fall_i)     top_n = sr_q[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      top_q <= 1'b0;
    end else begin
      sr_q  <= sr_n;
      top_q <= top_n;
    end
  end

  assign word_o  = sr_q;
  assign top_q_o = top_q;

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en_i |=> (sr_q[0] == $past(din_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));

  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(sr_q));

  // R9
  fall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_i |=> top_q == $past(sr_q[W-1]));
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [CTRL_W-1:0] l1_ctrl_o,
  output logic [RDIV_W-1:0] l1_rdiv_o,
  output logic [MDIV_W-1:0] l1_mdiv_o,
  output logic [SW1_W-1:0]  l1_swal_o,
  output logic [FRAC_W-1:0] l1_frac_o,
  output logic [CTRL_W-1:0] l2_ctrl_o,
  output logic [RDIV_W-1:0] l2_rdiv_o,
  output logic [MDIV_W-1:0] l2_mdiv_o,
  output logic [SW2_W-1:0]  l2_swal_o,
  output logic [FRAC_W-1:0] l2_frac_o,
  output logic              test_o
);
  localparam int unsigned REF2_W  = 1 + CTRL_W + RDIV_W;
  localparam int unsigned REF1_W  = CTRL_W + RDIV_W;
  localparam int unsigned MAIN1_W = MDIV_W + SW1_W + FRAC_W;
  localparam int unsigned MAIN2_W = MDIV_W + SW2_W + FRAC_W;
  localparam int unsigned LO = ADDR_W;

  logic [REF2_W-1:0]  ref2_q,  ref2_n;
  logic [REF1_W-1:0]  ref1_q,  ref1_n;
  logic [MAIN1_W-1:0] main1_q, main1_n;
  logic [MAIN2_W-1:0] main2_q, main2_n;
  cfg_addr_e          addr;

  assign addr = cfg_addr_e'(word_i[ADDR_W-1:0]);

  always_comb begin
    ref2_n  = ref2_q;
    ref1_n  = ref1_q;
    main1_n = main1_q;
    main2_n = main2_q;
    if (load_i) begin
      unique case (addr)
        ADR_L2_REF:  ref2_n  = word_i[LO+REF2_W-1:LO];
        ADR_L1_REF:  ref1_n  = word_i[LO+REF1_W-1:LO];
        ADR_L1_MAIN: main1_n = word_i[LO+MAIN1_W-1:LO];
        ADR_L2_MAIN: main2_n = word_i[LO+MAIN2_W-1:LO];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref2_q  <= '0;
      ref1_q  <= '0;
      main1_q <= '0;
      main2_q <= '0;
    end else begin
      ref2_q  <= ref2_n;
      ref1_q  <= ref1_n;
      main1_q <= main1_n;
      main2_q <= main2_n;
    end
  end

  assign {test_o, l2_ctrl_o, l2_rdiv_o}       = ref2_q;
  assign {l1_ctrl_o, l1_rdiv_o}               = ref1_q;
  assign {l1_mdiv_o, l1_swal_o, l1_frac_o}    = main1_q;
  assign {l2_mdiv_o, l2_swal_o, l2_frac_o}    = main2_q;

  // R7
  no_load_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable({ref2_q, ref1_q, main1_q, main2_q}));

  // R7
  other_regs_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[1:0] == 2'b11) |=> $stable({ref2_q, ref1_q, main2_q}));

  // R5
  main1_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[1:0] == 2'b11) |=>
      {l1_mdiv_o, l1_swal_o, l1_frac_o} == $past(word_i[20:2]));

  // R3
  test_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && word_i[1:0] == 2'b00) |=> test_o == $past(word_i[16]));
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import serial_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  output logic [CTRL_W-1:0] l1_ctrl_o,
  output logic [RDIV_W-1:0] l1_rdiv_o,
  output logic [MDIV_W-1:0] l1_mdiv_o,
  output logic [SW1_W-1:0]  l1_swal_o,
  output logic [FRAC_W-1:0] l1_frac_o,
  output logic [CTRL_W-1:0] l2_ctrl_o,
  output logic [RDIV_W-1:0] l2_rdiv_o,
  output logic [MDIV_W-1:0] l2_mdiv_o,
  output logic [SW2_W-1:0]  l2_swal_o,
  output logic [FRAC_W-1:0] l2_frac_o,
  output logic              test_o,
  output logic              chain_o
);
  // reset: asserted asynchronously, released on clk
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [2:0] raw_in, syn_in;
  assign raw_in = {ser_le_i, ser_data_i, ser_clk_i};

  sync_chain #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  logic sck_s, dat_s, le_s;
  assign {le_s, dat_s, sck_s} = syn_in;

  logic sck_d_q, sck_d_n, le_d_q, le_d_n;
  always_comb begin
    sck_d_n = sck_s;
    le_d_n  = le_s;
  end
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      sck_d_q <= 1'b0;
      le_d_q  <= 1'b0;
    end else begin
      sck_d_q <= sck_d_n;
      le_d_q  <= le_d_n;
    end
  end

  logic sck_rise, sck_fall, le_rise, shift_en, shift_hold;
  assign sck_rise   = sck_s & ~sck_d_q;
  assign sck_fall   = ~sck_s & sck_d_q;
  assign le_rise    = le_s & ~le_d_q;
  assign shift_en   = sck_rise & ~le_s;
  assign shift_hold = le_s;

  logic [WORD_W-1:0] word;
  logic              top_q;

  shift_core #(.W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .shift_en_i (shift_en),
    .hold_i     (shift_hold),
    .din_i      (dat_s),
    .fall_i     (sck_fall),
    .word_o     (word),
    .top_q_o    (top_q)
  );

  cfg_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .load_i    (le_rise),
    .word_i    (word),
    .l1_ctrl_o (l1_ctrl_o),
    .l1_rdiv_o (l1_rdiv_o),
    .l1_mdiv_o (l1_mdiv_o),
    .l1_swal_o (l1_swal_o),
    .l1_frac_o (l1_frac_o),
    .l2_ctrl_o (l2_ctrl_o),
    .l2_rdiv_o (l2_rdiv_o),
    .l2_mdiv_o (l2_mdiv_o),
    .l2_swal_o (l2_swal_o),
    .l2_frac_o (l2_frac_o),
    .test_o    (test_o)
  );

  logic chain_sel;
  assign chain_sel = (l1_ctrl_o[CTRL_W-1 -: 2] == SEL_CHAIN) &&
                     (l2_ctrl_o[CTRL_W-1 -: 2] == SEL_CHAIN);
  assign chain_o   = chain_sel & top_q;

  // R9
  chain_follows_fall_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sck_fall && chain_sel) |=> $past(chain_sel) && (chain_o == $past(word[WORD_W-1])) || !chain_sel);
endmodule

// File: tb/test_serial_cfg_port.sv
module test_serial_cfg_port;
  logic clk, rst_n, sck, sdat, sle;
  logic [4:0] l1_ctrl, l1_swal, l1_frac, l2_ctrl, l2_frac;
  logic [8:0] l1_rdiv, l1_mdiv, l2_rdiv, l2_mdiv;
  logic [3:0] l2_swal;
  logic       test_b, chain;

  serial_cfg_port i_serial_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_data_i(sdat), .ser_le_i(sle),
    .l1_ctrl_o(l1_ctrl), .l1_rdiv_o(l1_rdiv), .l1_mdiv_o(l1_mdiv),
    .l1_swal_o(l1_swal), .l1_frac_o(l1_frac),
    .l2_ctrl_o(l2_ctrl), .l2_rdiv_o(l2_rdiv), .l2_mdiv_o(l2_mdiv),
    .l2_swal_o(l2_swal), .l2_frac_o(l2_frac),
    .test_o(test_b), .chain_o(chain)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string      tag;
    logic [4:0] c1, s1, f1, c2, f2;
    logic [8:0] r1, m1, r2, m2;
    logic [3:0] s2;
    logic       tb;
  } exp_t;

  exp_t       model;
  exp_t       sb_q[$];
  logic [20:0] sr_model;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit chk_chain = 0;

  function automatic void chk(string tag, string fld, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, fld, act, exp);
    end
  endfunction

  // bench-side decode of a loaded word, from the requirement layouts
  function automatic void apply_word(logic [20:0] w);
    case (w[1:0])
      2'b00: begin model.tb = w[16]; model.c2 = w[15:11]; model.r2 = w[10:2]; end
      2'b10: begin model.c1 = w[15:11]; model.r1 = w[10:2]; end
      2'b11: begin model.m1 = w[20:12]; model.s1 = w[11:7]; model.f1 = w[6:2]; end
      default: begin model.m2 = w[19:11]; model.s2 = w[10:7]; model.f2 = w[6:2]; end
    endcase
  endfunction

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ser_bit(logic b);
    logic e;
    sdat = b;
    wait_n(8);
    sck = 1'b1;
    if (!sle) sr_model = {sr_model[19:0], b};
    wait_n(8);
    sck = 1'b0;
    wait_n(8);
    if (chk_chain) begin
      e = (model.c1[4:3] == 2'b10 && model.c2[4:3] == 2'b10) ? sr_model[20] : 1'b0;
      chk("R9", "chain_o", chain, e);
    end
  endtask

  task automatic shift_word(logic [20:0] w);
    for (int i = 20; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic strobe();
    wait_n(8);
    sle = 1'b1;
    wait_n(8);
    sle = 1'b0;
    wait_n(8);
  endtask

  task automatic push(string tag);
    exp_t e;
    e = model;
    e.tag = tag;
    sb_q.push_back(e);
    wait_n(4);
  endtask

  task automatic load(logic [20:0] w, string tag);
    shift_word(w);
    strobe();
    apply_word(w);
    push(tag);
  endtask

  // monitor: compares each expected item against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "l1_ctrl", l1_ctrl, e.c1);
        chk(e.tag, "l1_rdiv", l1_rdiv, e.r1);
        chk(e.tag, "l1_mdiv", l1_mdiv, e.m1);
        chk(e.tag, "l1_swal", l1_swal, e.s1);
        chk(e.tag, "l1_frac", l1_frac, e.f1);
        chk(e.tag, "l2_ctrl", l2_ctrl, e.c2);
        chk(e.tag, "l2_rdiv", l2_rdiv, e.r2);
        chk(e.tag, "l2_mdiv", l2_mdiv, e.m2);
        chk(e.tag, "l2_swal", l2_swal, e.s2);
        chk(e.tag, "l2_frac", l2_frac, e.f2);
        chk(e.tag, "test",    test_b,  e.tb);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sck = 1'b0; sdat = 1'b0; sle = 1'b0;
    sr_model = '0;
    model = '{tag: "", c1: 0, s1: 0, f1: 0, c2: 0, f2: 0,
              r1: 0, m1: 0, r2: 0, m2: 0, s2: 0, tb: 0};
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    // R1: reset state
    push("R1");
    chk("R1", "chain_o", chain, 0);

    // R5 R7: loop-1 main word
    load({9'h1A5, 5'h13, 5'h0B, 2'b11}, "R5 R7 main1");
    // R6 R10: loop-2 main word with reserved bit 20 set
    load({1'b1, 9'h0F3, 4'hA, 5'h15, 2'b01}, "R6 R10 main2");
    // R3 R10: loop-2 reference with reserved 20..17 set and test bit 1
    load({4'hF, 1'b1, 5'b10110, 9'h123, 2'b00}, "R3 R10 ref2");
    // R4 R10: loop-1 reference with reserved 20..16 set
    load({5'h1F, 5'b01101, 9'h0AB, 2'b10}, "R4 R10 ref1");
    // R3: test bit back to 0
    load({4'h0, 1'b0, 5'b00110, 9'h1FE, 2'b00}, "R3 ref2");
    // R2: all-ones and alternating patterns
    load({9'h1FF, 5'h1F, 5'h1F, 2'b11}, "R2 R5 ones");
    load({9'h0AA, 5'h15, 5'h0A, 2'b11}, "R2 R5 alt");

    // R8: clock edges under a held strobe are ignored; reload is identical
    shift_word({9'h155, 5'h06, 5'h19, 2'b11});
    wait_n(8);
    sle = 1'b1;
    wait_n(8);
    for (int k = 0; k < 3; k++) ser_bit(1'b0);
    sle = 1'b0;
    wait_n(8);
    apply_word({9'h155, 5'h06, 5'h19, 2'b11});
    push("R8 held strobe");
    strobe();
    push("R8 reload");

    // R9: select the chain output on both loops
    load({5'h00, 5'b10011, 9'h0AB, 2'b10}, "R4 R9 sel1");
    load({4'h0, 1'b0, 5'b10001, 9'h1FE, 2'b00}, "R3 R9 sel2");
    chk_chain = 1;
    shift_word(21'h1B3C5A);
    shift_word(21'h0F0F0F);
    chk_chain = 0;
    // R9: deselect loop 1, chain must stay 0
    load({5'h00, 5'b11011, 9'h0AB, 2'b10}, "R4 R9 desel");
    chk_chain = 1;
    shift_word(21'h1FFFFF);
    chk_chain = 0;

    wait_n(10);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule